// File: doc/BRIEF.md
# Shared-Flag Pin Interrupt Controller

This block watches a group of general-purpose input pins and raises one interrupt flag that all of them share. Each pin passes through a synchronizer. A per-pin polarity bit then sets its active level, and a per-pin enable bit removes it from detection. The adjusted pins are ORed into one combined "any active" signal. The flag is set when that combined signal moves from inactive to active.

Because there is only one flag behind a single OR, a pin that is held at its active level hides the edges of every other enabled pin until it goes inactive. Software clears the flag with a one-cycle acknowledge strobe. A mode bit selects one of two behaviours. In edge-only mode the flag records only the transition. In edge-and-level mode the flag is forced on for as long as any enabled pin is active. The interrupt request is the flag gated by a global enable.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, `flagOut` and `irqOut` are 0.
- R2: A pin with `pinPolarity` bit 0 is active when high. A pin with `pinPolarity` bit 1 is active when low. When an enabled pin moves from inactive to active while every other enabled pin is inactive, `flagOut` becomes 1.
- R3: A pin whose `pinEnable` bit is 0 has no effect on `flagOut`, whatever its level does.
- R4: While any enabled pin is at its active level, an inactive-to-active change on another enabled pin does not set `flagOut`.
- R5: Once set, `flagOut` stays 1 until `ackStrobe` is high on a rising clock edge. In edge-only mode (`levelMode`=0) that acknowledge clears the flag, even if a pin is still active.
- R6: If `ackStrobe` is high in the same cycle in which a new combined edge is detected, the set wins and `flagOut` stays 1.
- R7: With `levelMode`=1, `flagOut` is set again on every cycle in which an enabled pin is active. An acknowledge clears it only after all enabled pins are inactive.
- R8: `irqOut` is 1 exactly when `flagOut` is 1 and `irqEnable` is 1.
- R9: Changing `pinEnable` or `pinPolarity` so that a pin that is already steady becomes active does not set `flagOut`.
- R10: A pin change that is applied just before a rising edge shows on `flagOut` after the third rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous |
| pinIn | input | 8 | Raw pin levels |
| pinEnable | input | 8 | Per-pin detection enable |
| pinPolarity | input | 8 | Per-pin active level: 1 = active low |
| levelMode | input | 1 | 0 = edge only, 1 = edge and level |
| irqEnable | input | 1 | Global interrupt request enable |
| ackStrobe | input | 1 | One-cycle flag clear |
| flagOut | output | 1 | Shared interrupt flag |
| irqOut | output | 1 | Interrupt request |

## Verification
A stale previous-sample register would show as a flag set by a configuration write alone, or as a masked edge that still gets through. Either error appears three cycles after the stimulus. A wrong priority between set and clear shows on `flagOut` in the cycle after an acknowledge that meets a new edge. Level mode that fails to re-force the flag shows as a flag that drops one cycle after an acknowledge while a pin is still held active.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
  } flagCtl_t;
endpackage

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinEnable,
  input  logic [NUM_PINS-1:0] pinPolarity,
  input  flagCtl_t            strobes,
  output logic                anyActive,
  output logic                newEdge,
  output logic                flag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncPipe;
  logic [NUM_PINS-1:0] pinNow;
  logic [NUM_PINS-1:0] pinPrev;
  logic [NUM_PINS-1:0] curAdj;
  logic [NUM_PINS-1:0] prevAdj;
  logic prevActive;

  // Synchronizer chain, one column per pin.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], pinIn};
  end

  assign pinNow = syncPipe[LAST];

  // Raw previous sample. It is re-judged with the present configuration,
  // so a configuration change cannot fake an edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinNow;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_adjust
    assign curAdj[i]  = pinEnable[i] & (pinNow[i]  ^ pinPolarity[i]);
    assign prevAdj[i] = pinEnable[i] & (pinPrev[i] ^ pinPolarity[i]);
  end

  assign anyActive  = |curAdj;
  assign prevActive = |prevAdj;
  assign newEdge    = anyActive & ~prevActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                flag <= 1'b0;
    else if (strobes.setFlag) flag <= 1'b1;
    else if (strobes.clrFlag) flag <= 1'b0;
  end

  // R2
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    newEdge |=> flag);

  // R4
  no_set_while_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevActive && !strobes.setFlag && !flag) |=> !flag);
endmodule

// File: rtl/pin_irq_control.sv
module pin_irq_control
  import pin_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ackStrobe,
  input  logic     levelMode,
  input  logic     irqEnable,
  input  logic     anyActive,
  input  logic     newEdge,
  input  logic     flag,
  output flagCtl_t strobes,
  output logic     irqOut
);
  logic forceSet;

  assign forceSet        = newEdge | (levelMode & anyActive);
  assign strobes.setFlag = forceSet;
  assign strobes.clrFlag = ackStrobe & ~forceSet;
  assign irqOut          = flag & irqEnable;

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !ackStrobe) |=> flag);

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !newEdge && !(levelMode && anyActive)) |=> !flag);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && newEdge) |=> flag);

  // R7
  level_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelMode && anyActive) |=> flag);

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (flag && irqEnable));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinEnable,
  input  logic [NUM_PINS-1:0] pinPolarity,
  input  logic                levelMode,
  input  logic                irqEnable,
  input  logic                ackStrobe,
  output logic                flagOut,
  output logic                irqOut
);
  flagCtl_t strobes;
  logic anyActive;
  logic newEdge;

  pin_irq_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinEnable(pinEnable),
    .pinPolarity(pinPolarity), .strobes(strobes), .anyActive(anyActive),
    .newEdge(newEdge), .flag(flagOut)
  );

  pin_irq_control ctl_i (
    .clk(clk), .rstN(rstN), .ackStrobe(ackStrobe), .levelMode(levelMode),
    .irqEnable(irqEnable), .anyActive(anyActive), .newEdge(newEdge),
    .flag(flagOut), .strobes(strobes), .irqOut(irqOut)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !flagOut);
endmodule

// File: tb/pin_irq_ctrl_tb_top.sv
module pin_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pinIn = '0;
  logic [7:0] pinEnable = '0;
  logic [7:0] pinPolarity = '0;
  logic levelMode = 1'b0;
  logic irqEnable = 1'b1;
  logic ackStrobe = 1'b0;
  logic flagOut, irqOut;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinEnable(pinEnable),
    .pinPolarity(pinPolarity), .levelMode(levelMode), .irqEnable(irqEnable),
    .ackStrobe(ackStrobe), .flagOut(flagOut), .irqOut(irqOut)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic actual, input logic expected, input string req);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, actual, expected);
    end
  endtask

  task automatic ack();
    ackStrobe = 1'b1; tick(1); ackStrobe = 1'b0;
  endtask

  task automatic test_reset();
    check(flagOut, 1'b0, "R1 flag");
    check(irqOut, 1'b0, "R1 irq");
  endtask

  task automatic test_latency_and_hold();
    pinEnable = 8'h03; pinPolarity = '0; tick(4);
    pinIn[0] = 1'b1;
    tick(2); check(flagOut, 1'b0, "R10 not after second edge");
    tick(1); check(flagOut, 1'b1, "R10 after third edge");
    check(irqOut, 1'b1, "R8 irq follows flag");
    pinIn[0] = 1'b0; tick(4);
    check(flagOut, 1'b1, "R5 hold without ack");
  endtask

  task automatic test_set_wins_and_mask();
    pinIn[1] = 1'b1;
    tick(2); ackStrobe = 1'b1; tick(1); ackStrobe = 1'b0;
    check(flagOut, 1'b1, "R6 set beats ack");
    ack();
    check(flagOut, 1'b0, "R5 ack clears while active");
    pinIn[0] = 1'b1; tick(5);
    check(flagOut, 1'b0, "R4 masked edge");
    pinIn[1:0] = 2'b00; tick(5);
    check(flagOut, 1'b0, "R4 release no set");
  endtask

  task automatic test_config_and_polarity();
    pinPolarity[3] = 1'b1; pinEnable[3] = 1'b1; tick(5);
    check(flagOut, 1'b0, "R9 config change no set");
    pinIn[3] = 1'b1; tick(5);
    check(flagOut, 1'b0, "R2 active low going inactive");
    pinIn[3] = 1'b0; tick(3);
    check(flagOut, 1'b1, "R2 active low edge");
    ack(); pinEnable[3] = 1'b0; tick(2);
    pinIn[5] = 1'b1; tick(5);
    check(flagOut, 1'b0, "R3 disabled pin high");
    pinIn[5] = 1'b0; tick(5);
    check(flagOut, 1'b0, "R3 disabled pin low");
  endtask

  task automatic test_level_mode();
    levelMode = 1'b1;
    pinIn[0] = 1'b1; tick(3);
    check(flagOut, 1'b1, "R7 set");
    ack(); tick(1);
    check(flagOut, 1'b1, "R7 ack ignored while active");
    pinIn[0] = 1'b0; tick(3);
    ack();
    check(flagOut, 1'b0, "R7 ack clears once inactive");
    levelMode = 1'b0;
  endtask

  task automatic test_irq_gate();
    pinIn[1] = 1'b1; tick(3);
    irqEnable = 1'b0; tick(1);
    check(flagOut, 1'b1, "R8 flag set");
    check(irqOut, 1'b0, "R8 gated off");
    irqEnable = 1'b1; tick(1);
    check(irqOut, 1'b1, "R8 gated on");
    ack();
    check(irqOut, 1'b0, "R8 off after ack");
  endtask

  initial begin
    tick(3);
    test_reset();
    rstN = 1'b1; tick(2);
    test_reset();
    test_latency_and_hold();
    test_set_wins_and_mask();
    test_config_and_polarity();
    test_level_mode();
    test_irq_gate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule